// File: doc/BRIEF.md
# Counting Semaphore Cell with Blocking Waiters

This block holds one counting semaphore shared by a set of requesters. A read request takes one unit from the count and a write request gives one unit back. Each request carries a view bit. In the blocking view, a reader that finds the count at zero is stalled and joins a waiting set. In the try view, the same reader only gets the zero value back.

The waiting set is a bitmask with one bit per requester ID. The next write releases every waiter at once through a one-cycle wake mask, and the waiting set is then cleared. A woken requester issues its read again. That new read sees the count as it stands at that moment, so a waiter may have to wait again.

All outputs are registered. The response to a request appears on the cycle after the request is accepted. There is no back-pressure, and one request can be accepted every cycle.

Top module: `sema_cell`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, empties the waiting set and drives `resp_valid`, `stall`, `rd_data` and `wake_mask` to 0. Waiters recorded before the reset are never woken.
- R2: A read (`req_write`=0) returns on `rd_data` the count as it stood before the request, zero-extended.
- R3: A read that finds the count above 0 lowers it by one.
- R4: A blocking-view read (`req_view`=1) that finds the count at 0 sets `stall`, returns 0, leaves the count at 0 and adds bit `req_id` to the waiting set.
- R5: A try-view read (`req_view`=0) that finds the count at 0 returns 0 with `stall` low, and it does not add the requester to the waiting set.
- R6: A write (`req_write`=1) raises the count by one. When the count is already all ones (2^CNT_W-1), the count stays there. The value on `wr_data` has no effect.
- R7: A write while the waiting set is non-empty drives `wake_mask` with the waiting set for exactly one cycle and empties the set. A write with an empty set leaves `wake_mask` at 0.
- R8: The view bit has no effect on writes.
- R9: Every accepted request gives `resp_valid`=1 on the next cycle. A cycle without a request gives `resp_valid`, `stall` and `wake_mask` all 0 on the next cycle. A write returns `rd_data`=0.
- R10: A read issued again after a wake is evaluated against the current count. If another requester has already taken the unit, the read stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = give (write), 0 = take (read) |
| req_view | input | 1 | 1 = blocking view, 0 = try view |
| req_id | input | ID_W | Requester identifier |
| wr_data | input | DATA_W | Write data, ignored |
| resp_valid | output | 1 | Response for the previous cycle's request |
| rd_data | output | DATA_W | Count before a read, 0 otherwise |
| stall | output | 1 | Read was parked in the waiting set |
| wake_mask | output | 2^ID_W | One-cycle release of waiting requesters |

## Verification
The bench builds the cell with CNT_W=4, ID_W=3 and DATA_W=16. With these values saturation is reached after fifteen writes, and an eight-bit wake mask fits in one table field. This makes the all-ones ceiling, the release of several waiters at once and the race after a wake (one waiter takes the unit, the other stalls again) reachable within a short table. Directed tests add the ceiling, the ignored write data, idle cycles and a reset that drops the parked waiters.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic {
    VIEW_TRY   = 1'b0,
    VIEW_BLOCK = 1'b1
  } view_e;

  typedef enum logic {
    OP_TAKE = 1'b0,
    OP_GIVE = 1'b1
  } op_e;
endpackage

// File: rtl/sema_counter.sv
module sema_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             give,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             is_zero,
  output logic             is_full
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  assign is_zero = (count == '0);
  assign is_full = (count == CEIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (give) begin
      if (!is_full) count <= count + 1'b1;
    end else if (take) begin
      if (!is_zero) count <= count - 1'b1;
    end
  end

  assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
    (give && is_full) |=> (count == CEIL));
  assert_take_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !give && !is_zero) |=> (count == $past(count) - 1'b1));
  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (take && !give && is_zero) |=> is_zero);
endmodule

// File: rtl/sema_waitset.sv
module sema_waitset #(
  parameter int ID_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              park,
  input  logic [ID_W-1:0]   park_id,
  input  logic              release_all,
  output logic [(1<<ID_W)-1:0] waiting,
  output logic [(1<<ID_W)-1:0] wake_q
);
  localparam int NREQ = 1 << ID_W;

  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        waiting[i] <= 1'b0;
        wake_q[i]  <= 1'b0;
      end else if (release_all) begin
        wake_q[i]  <= waiting[i];
        waiting[i] <= 1'b0;
      end else begin
        wake_q[i] <= 1'b0;
        if (park && (park_id == ID_W'(i))) waiting[i] <= 1'b1;
      end
    end
  end

  assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
    release_all |=> (waiting == '0));
  assert_park_R4: assert property (@(posedge clk) disable iff (rst)
    (park && !release_all) |=> waiting[$past(park_id)]);
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !release_all |=> (wake_q == '0));
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ID_W   = 6,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_view,
  input  logic [ID_W-1:0]      req_id,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 resp_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 stall,
  output logic [(1<<ID_W)-1:0] wake_mask
);
  localparam int NREQ = 1 << ID_W;

  logic             do_give, do_take, do_park;
  logic [CNT_W-1:0] count;
  logic             is_zero, is_full;
  logic [NREQ-1:0]  waiting;
  logic             unused_wdata;

  assign unused_wdata = ^wr_data;

  assign do_give = req_valid && (op_e'(req_write) == OP_GIVE);
  assign do_take = req_valid && (op_e'(req_write) == OP_TAKE);
  assign do_park = do_take && is_zero && (view_e'(req_view) == VIEW_BLOCK);

  sema_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .give    (do_give),
    .take    (do_take),
    .count   (count),
    .is_zero (is_zero),
    .is_full (is_full)
  );

  sema_waitset #(.ID_W(ID_W)) u_waitset (
    .clk         (clk),
    .rst         (rst),
    .park        (do_park),
    .park_id     (req_id),
    .release_all (do_give),
    .waiting     (waiting),
    .wake_q      (wake_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      rd_data    <= '0;
      stall      <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      stall      <= do_park;
      rd_data    <= do_take ? DATA_W'(count) : '0;
    end
  end

  assert_resp_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !stall && wake_mask == '0));
  assert_stall_zero_R4: assert property (@(posedge clk) disable iff (rst)
    stall |-> (resp_valid && rd_data == '0));
  assert_try_nostall_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !req_view) |=> !stall);
  assert_write_data_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rd_data == '0 && !stall));
endmodule

// File: tb/sema_cell_bench.sv
`timescale 1ns/1ps
module sema_cell_bench;
  localparam int CNT_W  = 4;
  localparam int ID_W   = 3;
  localparam int DATA_W = 16;
  localparam int NREQ   = 1 << ID_W;

  typedef struct packed {
    logic            wr;
    logic            blk;
    logic [ID_W-1:0] id;
    logic [CNT_W-1:0] exp_data;
    logic            exp_stall;
    logic [NREQ-1:0] exp_wake;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    {1'b0, 1'b0, 3'd0, 4'd0, 1'b0, 8'h00},  // R5 try read at zero
    {1'b0, 1'b1, 3'd2, 4'd0, 1'b1, 8'h00},  // R4 park id2
    {1'b0, 1'b1, 3'd5, 4'd0, 1'b1, 8'h00},  // R4 park id5
    {1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 8'h24},  // R7 release both
    {1'b0, 1'b1, 3'd2, 4'd1, 1'b0, 8'h00},  // R10 id2 wins
    {1'b0, 1'b1, 3'd5, 4'd0, 1'b1, 8'h00},  // R10 id5 parks again
    {1'b1, 1'b1, 3'd0, 4'd0, 1'b0, 8'h20},  // R8 blocking-view write
    {1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 8'h00},  // R7 empty set
    {1'b1, 1'b1, 3'd0, 4'd0, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd1, 4'd3, 1'b0, 8'h00},  // R2 R3
    {1'b0, 1'b1, 3'd1, 4'd2, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd1, 4'd1, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd4, 4'd0, 1'b0, 8'h00},  // R5
    {1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 8'h00},  // R5 nobody parked
    {1'b0, 1'b0, 3'd0, 4'd1, 1'b0, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_view = 1'b0;
  logic [ID_W-1:0]   req_id = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] rd_data;
  logic              stall;
  logic [NREQ-1:0]   wake_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sema_cell #(.CNT_W(CNT_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_sema_cell (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_id(req_id), .wr_data(wr_data),
    .resp_valid(resp_valid), .rd_data(rd_data), .stall(stall),
    .wake_mask(wake_mask)
  );

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic issue(logic wr, logic blk, logic [ID_W-1:0] id, logic [DATA_W-1:0] d);
    req_valid = 1'b1; req_write = wr; req_view = blk; req_id = id; wr_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 resp_valid", resp_valid, 0);
    check("R1 stall", stall, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 wake_mask", wake_mask, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].blk, VECS[i].id, DATA_W'(16'hA5C3 + i));
      check($sformatf("R9 vec%0d resp_valid", i), resp_valid, 1);
      check($sformatf("R2 vec%0d rd_data", i), rd_data, VECS[i].exp_data);
      check($sformatf("R4 vec%0d stall", i), stall, VECS[i].exp_stall);
      check($sformatf("R7 vec%0d wake_mask", i), wake_mask, VECS[i].exp_wake);
    end

    // R9 idle cycle gives quiet outputs
    @(negedge clk);
    check("R9 idle resp_valid", resp_valid, 0);
    check("R9 idle wake_mask", wake_mask, 0);

    // R6 saturation with varying write data
    do_reset();
    for (int i = 0; i < 18; i++) issue(1'b1, 1'b0, '0, DATA_W'(i * 16'h1111));
    issue(1'b0, 1'b0, 3'd6, '0);
    check("R6 ceiling hold", rd_data, 15);
    issue(1'b0, 1'b0, 3'd6, '0);
    check("R6 after ceiling take", rd_data, 14);

    // R6 write data has no effect: two writes with extreme data add exactly two
    do_reset();
    issue(1'b1, 1'b0, '0, '1);
    issue(1'b1, 1'b0, '0, '0);
    issue(1'b0, 1'b0, '0, '0);
    check("R6 wr_data ignored", rd_data, 2);

    // R1 reset drops parked waiters
    do_reset();
    issue(1'b0, 1'b1, 3'd3, '0);
    check("R4 park id3 stall", stall, 1);
    do_reset();
    check("R1 stall after reset", stall, 0);
    issue(1'b1, 1'b1, '0, '0);
    check("R1 no wake after reset", wake_mask, 0);
    issue(1'b0, 1'b0, '0, '0);
    check("R1 count after reset", rd_data, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule